// File: doc/BRIEF.md
# Fixed-Step Simulation Master Sequencer

This block is the central controller of a fixed-step real-time hardware simulator. The modelled circuit is split into a nonlinear partition and a linear partition. Each partition is made of several hardware sub-circuits. The sequencer drives one set of control lines that every sub-circuit receives. It collects one completion flag from each sub-circuit and walks every time step through a fixed order: compute the nonlinear partition, compute the linear partition, trade data with the output converters, trade data with the host processor, and then commit the new state at the step boundary.

The nonlinear partition is started first, and the linear partition is started only after every nonlinear completion flag is high. The nonlinear result therefore reaches the linear solver inside the same step, and the loop carries a single step of delay. A parameter selects a parallel variant in which both partitions start together and the sequencer waits on every flag.

A programmable step timer places each start pulse a fixed number of cycles after the previous one. A late step commits as soon as its work ends and raises a sticky overrun flag. After reset, the sub-circuits are held in reset for a programmable number of cycles and then receive one commit of zeroed state. The two exchange phases use request/acknowledge handshakes. A handshake that stalls beyond a programmable limit sends the machine back to initialization.

Top module: `step_sequencer`

## Requirements
- R1: While `rst_n` is low and for `init_len` cycles after it rises (a value of 0 counts as 1), `sub_rst` is 1, `sub_en` is 0, and no start, commit or request line is high. `overrun` is cleared by `rst_n`.
- R2: In the cycle after initialization ends, `commit_nl` and `commit_lin` are high for one cycle with `sub_en` 0, and `start_nl` follows in the next cycle.
- R3: Start lines are single-cycle pulses. `eoc` bit i belongs to the nonlinear partition when `NL_MASK` bit i is 1 (default 4'b0011) and to the linear partition otherwise. `start_lin` rises exactly one cycle after the first cycle in which every nonlinear flag is high.
- R4: `conv_req` rises one cycle after the first cycle in which every linear flag is high and stays high until the cycle in which `conv_ack` is seen. `host_req` rises in the cycle after that and stays high until `host_ack`.
- R5: When `host_ack` arrives no later than `period_cfg`-3 cycles after a `start_nl` pulse, the commit pulse comes `period_cfg`-1 cycles after that pulse, and the next `start_nl` comes `period_cfg` cycles after it.
- R6: When `host_ack` arrives later than that, the commit comes two cycles after the acknowledge cycle, the next start comes one cycle after the commit, and `overrun` becomes 1 in the commit cycle and stays 1 until reset.
- R7: A request that has been high for `timeout_cfg` cycles without an acknowledge drops, and `sub_rst` rises in the next cycle. The sequence of R1 and R2 is then repeated. An acknowledge in the last allowed cycle is accepted.
- R8: `sub_en` is 1 in every cycle from the first `start_nl` through each step's commit, and 0 during initialization and the zeroing commit.
- R9: `commit_nl` and `commit_lin` are only ever high together, only in the zeroing or step-boundary cycle, and always directly before a `start_nl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_cfg | input | TMR_W | Step period in cycles |
| init_len | input | CNT_W | Cycles of sub-circuit reset during initialization |
| timeout_cfg | input | CNT_W | Limit on cycles a request may wait for its acknowledge |
| eoc | input | N_SUB | End-of-computation flag from each sub-circuit |
| conv_ack | input | 1 | Converter exchange acknowledge |
| host_ack | input | 1 | Host processor exchange acknowledge |
| sub_rst | output | 1 | Reset broadcast to all sub-circuits |
| sub_en | output | 1 | Enable broadcast to all sub-circuits |
| start_nl | output | 1 | Start pulse for the nonlinear partition |
| start_lin | output | 1 | Start pulse for the linear partition |
| commit_nl | output | 1 | Register-commit strobe for the nonlinear partition |
| commit_lin | output | 1 | Register-commit strobe for the linear partition |
| conv_req | output | 1 | Converter exchange request |
| host_req | output | 1 | Host processor exchange request |
| overrun | output | 1 | Sticky flag: a step missed its period |

## Verification
Every output comes straight from the state register or the overrun register, so each one changes in the cycle after the input condition that causes it. A completion flag seen in cycle t gives the next start or request in cycle t+1. An acknowledge in cycle t gives the next request in cycle t+1. A timely step commits at the start cycle plus `period_cfg`-1. The bench models the sub-circuits and both acknowledgers with known latencies and computes every expected gap from these rules. It queues each strobe edge with its cycle distance from the one before, and it compares them at the falling edge, half a cycle away from the edges where the design changes.

// File: rtl/seq_pkg.sv
package seq_pkg;
   typedef enum logic [3:0] {
      SQ_INIT,
      SQ_ZERO,
      SQ_GO_NL,
      SQ_WAIT_NL,
      SQ_GO_LIN,
      SQ_WAIT_LIN,
      SQ_XCHG_CONV,
      SQ_XCHG_HOST,
      SQ_HOLD,
      SQ_COMMIT
   } seq_state_t;
endpackage

// File: rtl/seq_step_timer.sv
module seq_step_timer #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_start,
   input  logic             in_hold,
   input  logic [TMR_W-1:0] period,
   output logic             due,
   output logic             overrun
);
   localparam logic [TMR_W-1:0] T_ONE = 1;
   localparam logic [TMR_W:0]   X_ONE = 1;
   localparam logic [TMR_W:0]   X_TWO = 2;

   logic [TMR_W-1:0] tmr;
   logic [TMR_W:0]   t_ext, p_ext;
   logic             late;

   assign t_ext = {1'b0, tmr};
   assign p_ext = {1'b0, period};
   assign due   = (t_ext + X_TWO) >= p_ext;
   assign late  = (t_ext + X_ONE) >= p_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr     <= '0;
         overrun <= 1'b0;
      end else begin
         if (step_start)
            tmr <= T_ONE;
         else if (!(&tmr))
            tmr <= tmr + T_ONE;
         if (in_hold && late)
            overrun <= 1'b1;
      end
   end

   a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
   a_r6_overrun_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(in_hold));
endmodule

// File: rtl/seq_eoc_join.sv
module seq_eoc_join #(
   parameter int              N_SUB   = 4,
   parameter logic [N_SUB-1:0] NL_MASK = 4'b0011,
   parameter bit              SERIES  = 1'b1
) (
   input  logic [N_SUB-1:0] eoc,
   output logic             first_done,
   output logic             lin_done
);
   logic [N_SUB-1:0] nl_ok, lin_ok;
   logic             nl_done;

   for (genvar i = 0; i < N_SUB; i++) begin : g_flag
      assign nl_ok[i]  = !NL_MASK[i] || eoc[i];
      assign lin_ok[i] = NL_MASK[i]  || eoc[i];
   end

   assign nl_done  = &nl_ok;
   assign lin_done = &lin_ok;

   if (SERIES) begin : g_series
      assign first_done = nl_done;
   end else begin : g_parallel
      assign first_done = nl_done && lin_done;
   end
endmodule

// File: rtl/seq_phase_count.sv
module seq_phase_count #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [CNT_W-1:0] limit,
   output logic             hit
);
   localparam logic [CNT_W-1:0] C_ONE = 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   nxt;

   assign nxt = {1'b0, cnt} + {1'b0, C_ONE};
   assign hit = nxt >= {1'b0, limit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (!(&cnt))
         cnt <= cnt + C_ONE;
   end
endmodule

// File: rtl/step_sequencer.sv
module step_sequencer #(
   parameter int               N_SUB   = 4,
   parameter logic [N_SUB-1:0] NL_MASK = 4'b0011,
   parameter bit               SERIES  = 1'b1,
   parameter int               TMR_W   = 16,
   parameter int               CNT_W   = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TMR_W-1:0] period_cfg,
   input  logic [CNT_W-1:0] init_len,
   input  logic [CNT_W-1:0] timeout_cfg,
   input  logic [N_SUB-1:0] eoc,
   input  logic             conv_ack,
   input  logic             host_ack,
   output logic             sub_rst,
   output logic             sub_en,
   output logic             start_nl,
   output logic             start_lin,
   output logic             commit_nl,
   output logic             commit_lin,
   output logic             conv_req,
   output logic             host_req,
   output logic             overrun
);
   import seq_pkg::*;

   if (N_SUB < 2) begin : g_bad_n
      $error("step_sequencer: N_SUB must be at least 2");
   end
   if (NL_MASK == '0 || &NL_MASK) begin : g_bad_mask
      $error("step_sequencer: both partitions need at least one sub-circuit");
   end
   if (TMR_W < 4 || CNT_W < 2) begin : g_bad_w
      $error("step_sequencer: counter widths too small");
   end

   seq_state_t st, st_nxt;
   logic first_done, lin_done, due, hit;
   logic [CNT_W-1:0] limit;

   seq_eoc_join #(.N_SUB(N_SUB), .NL_MASK(NL_MASK), .SERIES(SERIES)) u_join (
      .eoc(eoc), .first_done(first_done), .lin_done(lin_done));

   seq_step_timer #(.TMR_W(TMR_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .step_start(st == SQ_GO_NL),
      .in_hold(st == SQ_HOLD), .period(period_cfg), .due(due), .overrun(overrun));

   assign limit = (st == SQ_INIT) ? init_len : timeout_cfg;

   seq_phase_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .clear(st_nxt != st), .limit(limit), .hit(hit));

   always_comb begin
      st_nxt = st;
      unique case (st)
         SQ_INIT:      if (hit) st_nxt = SQ_ZERO;
         SQ_ZERO:      st_nxt = SQ_GO_NL;
         SQ_GO_NL:     st_nxt = SQ_WAIT_NL;
         SQ_WAIT_NL:   if (first_done) st_nxt = SERIES ? SQ_GO_LIN : SQ_XCHG_CONV;
         SQ_GO_LIN:    st_nxt = SQ_WAIT_LIN;
         SQ_WAIT_LIN:  if (lin_done) st_nxt = SQ_XCHG_CONV;
         SQ_XCHG_CONV: if (conv_ack) st_nxt = SQ_XCHG_HOST;
                       else if (hit) st_nxt = SQ_INIT;
         SQ_XCHG_HOST: if (host_ack) st_nxt = SQ_HOLD;
                       else if (hit) st_nxt = SQ_INIT;
         SQ_HOLD:      if (due) st_nxt = SQ_COMMIT;
         SQ_COMMIT:    st_nxt = SQ_GO_NL;
         default:      st_nxt = SQ_INIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= SQ_INIT;
      else        st <= st_nxt;
   end

   assign sub_rst    = (st == SQ_INIT);
   assign sub_en     = !(st == SQ_INIT || st == SQ_ZERO);
   assign start_nl   = (st == SQ_GO_NL);
   assign commit_nl  = (st == SQ_ZERO || st == SQ_COMMIT);
   assign commit_lin = (st == SQ_ZERO || st == SQ_COMMIT);
   assign conv_req   = (st == SQ_XCHG_CONV);
   assign host_req   = (st == SQ_XCHG_HOST);

   if (SERIES) begin : g_lin_series
      assign start_lin = (st == SQ_GO_LIN);
      a_r3_lin_after_nl: assert property (@(posedge clk) disable iff (!rst_n)
         start_lin |-> $past(&(eoc | ~NL_MASK)));
   end else begin : g_lin_parallel
      assign start_lin = (st == SQ_GO_NL);
   end

   a_r1_quiet_in_init: assert property (@(posedge clk) disable iff (!rst_n)
      sub_rst |-> !(sub_en || start_nl || start_lin || commit_nl || conv_req || host_req));
   a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      start_nl |=> !start_nl);
   a_r4_one_exchange: assert property (@(posedge clk) disable iff (!rst_n)
      !(conv_req && host_req));
   a_r4_conv_held: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_ack) |=> (conv_req || sub_rst));
   a_r9_commit_then_start: assert property (@(posedge clk) disable iff (!rst_n)
      commit_nl |=> start_nl);
   a_r8_enabled_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_nl |-> sub_en);
endmodule

// File: tb/step_sequencer_bench.sv
module step_sequencer_bench;
   localparam int IL = 5;
   localparam int TO = 12;
   localparam int P  = 40;
   localparam logic [3:0] NLM = 4'b0011;

   logic clk = 0, rst_n = 0;
   logic [15:0] period_cfg;
   logic [11:0] init_len, timeout_cfg;
   logic [3:0]  eoc;
   logic conv_ack, host_ack;
   logic sub_rst, sub_en, start_nl, start_lin, commit_nl, commit_lin;
   logic conv_req, host_req, overrun;

   step_sequencer u_step_sequencer (
      .clk(clk), .rst_n(rst_n), .period_cfg(period_cfg), .init_len(init_len),
      .timeout_cfg(timeout_cfg), .eoc(eoc), .conv_ack(conv_ack), .host_ack(host_ack),
      .sub_rst(sub_rst), .sub_en(sub_en), .start_nl(start_nl), .start_lin(start_lin),
      .commit_nl(commit_nl), .commit_lin(commit_lin), .conv_req(conv_req),
      .host_req(host_req), .overrun(overrun));

   always #10 clk = ~clk;

   int total = 0, fails = 0, cyc = 0, last_cyc = 0;
   int lat[4];
   int scnt[4];
   int da_lat = 0, ca_lat = 0, dcnt = 0, hcnt = 0;
   bit ovr_seen = 0;
   int kq[$], dq[$], eq[$];
   string tq[$];
   logic p_rst = 1, p_conv = 0, p_host = 0, p_ovr = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // sub-circuit models: drop the flag on a start, raise it lat cycles later
   always @(posedge clk) begin
      for (int i = 0; i < 4; i++) begin
         if (!rst_n) begin
            eoc[i] <= 1'b1; scnt[i] <= 0;
         end else if ((NLM[i] && start_nl) || (!NLM[i] && start_lin)) begin
            eoc[i] <= 1'b0; scnt[i] <= lat[i];
         end else if (scnt[i] == 1) begin
            eoc[i] <= 1'b1; scnt[i] <= 0;
         end else if (scnt[i] > 1) begin
            scnt[i] <= scnt[i] - 1;
         end
      end
      dcnt <= conv_req ? dcnt + 1 : 0;
      hcnt <= host_req ? hcnt + 1 : 0;
   end
   assign conv_ack = conv_req && (dcnt == da_lat);
   assign host_ack = host_req && (hcnt == ca_lat);

   task automatic chk(bit ok, string tag, int act, int exp, string what);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic push(int k, int d, int en, string tag);
      kq.push_back(k); dq.push_back(d); eq.push_back(en); tq.push_back(tag);
   endtask

   // kinds: 0 sub_rst rise, 1 commit, 2 start_nl, 3 start_lin, 4 conv_req rise,
   // 5 host_req rise, 6 overrun rise
   task automatic take(int k);
      if (kq.size() == 0) begin
         chk(0, "R9", k, -1, "unexpected strobe kind");
      end else begin
         int ek, ed, ee;
         string et;
         ek = kq.pop_front(); ed = dq.pop_front(); ee = eq.pop_front(); et = tq.pop_front();
         chk(ek == k, et, k, ek, "strobe kind");
         chk(cyc - last_cyc == ed, et, cyc - last_cyc, ed, "cycle gap");
         chk(sub_en == ee[0], "R8", int'(sub_en), ee, "enable level");
         last_cyc = cyc;
      end
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (sub_rst && !p_rst) take(0);
         if (commit_nl || commit_lin) begin
            take(1);
            chk(commit_nl && commit_lin, "R9", int'(commit_lin), 1, "commit pair");
         end
         if (start_nl) take(2);
         if (start_lin) take(3);
         if (conv_req && !p_conv) take(4);
         if (host_req && !p_host) take(5);
         if (overrun && !p_ovr) take(6);
      end
      p_rst = sub_rst; p_conv = conv_req; p_host = host_req; p_ovr = overrun;
   end

   // mode 0: normal, 1: converter timeout, 2: host timeout
   task automatic run_step(int n0, int n1, int l0, int l1, int da, int ca, int mode);
      int ln, ll, h;
      lat[0] = n0; lat[1] = n1; lat[2] = l0; lat[3] = l1;
      da_lat = da; ca_lat = ca;
      ln = (n0 > n1) ? n0 : n1;
      ll = (l0 > l1) ? l0 : l1;
      push(2, 1, 1, "R5");
      push(3, ln + 2, 1, "R3");
      push(4, ll + 2, 1, "R4");
      if (mode == 1) begin
         push(0, TO, 0, "R7");
         push(1, IL, 0, "R2");
      end else begin
         push(5, da + 1, 1, "R4");
         if (mode == 2) begin
            push(0, TO, 0, "R7");
            push(1, IL, 0, "R2");
         end else begin
            h = ln + ll + da + ca + 6;
            if (h <= P - 2) begin
               push(1, P - h + ca, 1, "R5");
            end else begin
               push(1, ca + 2, 1, "R6");
               if (!ovr_seen) push(6, 0, 1, "R6");
               ovr_seen = 1;
            end
         end
      end
      wait (kq.size() == 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; fails++;
      $display("FAIL R5 watchdog: got %0d expected %0d queued strobes", kq.size(), 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      period_cfg = 16'(P); init_len = 12'(IL); timeout_cfg = 12'(TO);
      for (int i = 0; i < 4; i++) lat[i] = 1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(sub_rst == 1, "R1", int'(sub_rst), 1, "reset sub_rst");
      chk(sub_en == 0, "R1", int'(sub_en), 0, "reset sub_en");
      chk(!(start_nl || start_lin || commit_nl || commit_lin), "R1", 1, 0, "reset strobes");
      chk(!(conv_req || host_req), "R1", 1, 0, "reset requests");
      chk(overrun == 0, "R1", int'(overrun), 0, "reset overrun");
      push(1, IL, 0, "R1");
      rst_n = 1; last_cyc = cyc;
      run_step(3, 6, 2, 4, 2, 1, 0);
      run_step(7, 1, 1, 5, 0, 3, 0);
      run_step(10, 10, 12, 3, 5, 5, 0);   // finishes exactly on time
      chk(overrun == 0, "R5", int'(overrun), 0, "on-time boundary overrun");
      run_step(2, 3, 4, 1, 20, 0, 1);     // converter stalls
      run_step(2, 2, 2, 2, 0, TO - 1, 0); // ack in last allowed cycle
      run_step(1, 1, 1, 1, 1, 50, 2);     // host stalls
      run_step(10, 10, 12, 3, 5, 6, 0);   // one cycle late
      run_step(1, 2, 3, 1, 1, 1, 0);
      chk(overrun == 1, "R6", int'(overrun), 1, "overrun sticky");
      rst_n = 0;
      #1;
      chk(overrun == 0, "R1", int'(overrun), 0, "overrun cleared by reset");
      chk(sub_rst == 1, "R1", int'(sub_rst), 1, "sub_rst in reset");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule